// File: doc/BRIEF.md
# Streaming 3×3 Convolution Pipeline

This block runs a 3×3 convolution over an image that arrives as a stream in raster order, one pixel position per clock. Each position carries one signed 8-bit sample for every input channel at once. Per channel, two row-wide line buffers hold the two previous rows, and a nine-register window holds the 3×3 neighbourhood ending at the current position. For every position, all output channels are computed in parallel. Each is a full dot product over every input channel and all nine taps, using weights loaded beforehand through a small write port.

Each 32-bit sum is requantized inline. A negative sum gives zero. A non-negative sum gives its bits 15 down to 8, which is an arithmetic shift right by eight truncated to a byte. The result for a whole position leaves as one wide word on a valid/ready stream, with a flag on the last position of each frame. A start-of-frame flag on the input clears all history, so the first rows of a frame never see pixels from the previous frame. No border suppression or padding is applied: every accepted position produces one output word.

Top module: `conv3x3_stream`

## Requirements
- R1: After reset, outValid and outLast are 0 and inReady is 1.
- R2: For an accepted position with stream index n, window tap (ky,kx) of channel ci holds that channel's sample from position n-(2-ky)*IMG_W-(2-kx). Here ky=0 is the top row, kx=0 the left column, and the tap code is ky*3+kx. At column 0 the left taps therefore hold the final columns of the preceding row.
- R3: Accepting a position with inSof high clears both line buffers and the window before that position enters. Taps that refer to positions before it read 0. That position is row 0, column 0.
- R4: Output channel k is the sum of tap(ci,t)×weight(k,ci,t) over all channels ci and tap codes t, with signed 8-bit operands and a 32-bit signed sum.
- R5: An output byte is 0 when its sum is negative. Otherwise it is bits [15:8] of the sum.
- R6: Channel i occupies bits [8i+7:8i] of inData. Output channel k occupies bits [8k+7:8k] of outData, so channels ascend from the least significant byte.
- R7: A weight write happens on a clock edge with wrEn high. wrAddr holds the tap code in bits [3:0], the input channel in the next CI_W bits and the output channel in the top CO_W bits. A tap code of 9 to 15, or a channel index out of range, changes no weight.
- R8: While outReady stays high, inReady stays high, so one position is accepted every cycle. A position accepted at one edge shows on outValid after the third edge that follows it.
- R9: While outValid is high and outReady is low, inReady is low and outData and outLast hold. No position is lost or repeated.
- R10: outLast is high with the output of the position at row IMG_H-1, column IMG_W-1, counted from the last start of frame.
- R11: Without a new start of frame, the position count wraps after IMG_W*IMG_H positions and the line-buffer history carries on across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input position valid |
| inReady | output | 1 | Input position accepted when high with inValid |
| inSof | input | 1 | Position is the first of a new frame |
| inData | input | CIN*8 | One signed sample per input channel |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | COUT*8 | One requantized byte per output channel |
| outLast | output | 1 | Output belongs to the last position of the frame |
| wrEn | input | 1 | Weight write strobe |
| wrAddr | input | CO_W+CI_W+4 | Weight address {output ch, input ch, tap code} |
| wrData | input | 8 | Signed weight value |

## Verification
The bench builds the block with a 5×4 image, three input channels and four output channels. With a 20-position frame, it can run frame wrap, mid-frame restarts and the last-position flag many times over. The narrow row makes the column-0 wrap of the left taps frequent. The three-channel count leaves an unused input-channel code, which the bench uses to probe the write port. Saturating all-127 and all -128 patterns reach the byte truncation and the negative clamp, and random gaps and stalls on both sides exercise the hold behaviour.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

  localparam int PIX_W       = 8;
  localparam int PROD_W      = 2 * PIX_W;
  localparam int ACC_W       = 32;
  localparam int TAPS        = 9;
  localparam int TAP_CODE_W  = 4;
  localparam int PIPE_STAGES = 4;   // window, tap sums, channel sum, output byte
  localparam int REQ_SHIFT   = 8;

  // Strobes handed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic adv;         // every pipeline stage may move this cycle
    logic accept;      // a new position enters the window
    logic frameStart;  // that position opens a frame
  } pipe_ctrl_t;

  // Zero clamp, then keep the byte above the fractional part.
  function automatic logic [PIX_W-1:0] requantize(input logic signed [ACC_W-1:0] sum);
    return sum[ACC_W-1] ? '0 : sum[REQ_SHIFT +: PIX_W];
  endfunction

endpackage

// File: rtl/conv3x3_ctrl.sv
module conv3x3_ctrl
  import conv3x3_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32,
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             outReady,
  output pipe_ctrl_t       ctrl,
  output logic [COL_W-1:0] col,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast
);

  logic [COL_W-1:0]       colReg;
  logic [ROW_W-1:0]       rowReg;
  logic [ROW_W-1:0]       curRow;
  logic [PIPE_STAGES-1:0] validPipe;
  logic [PIPE_STAGES-1:0] lastPipe;
  logic                   atRowEnd;
  logic                   atFrameEnd;
  logic                   adv;
  logic                   accept;

  assign outValid = validPipe[PIPE_STAGES-1];
  assign outLast  = lastPipe[PIPE_STAGES-1];

  // The whole pipeline moves together; it stops only when the output is blocked.
  assign adv     = !outValid || outReady;
  assign accept  = inValid && adv;
  assign inReady = adv;

  assign ctrl.adv        = adv;
  assign ctrl.accept     = accept;
  assign ctrl.frameStart = accept && inSof;

  assign col        = inSof ? '0 : colReg;
  assign curRow     = inSof ? '0 : rowReg;
  assign atRowEnd   = (col == COL_W'(IMG_W - 1));
  assign atFrameEnd = atRowEnd && (curRow == ROW_W'(IMG_H - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      colReg    <= '0;
      rowReg    <= '0;
      validPipe <= '0;
      lastPipe  <= '0;
    end else begin
      if (accept) begin
        colReg <= atRowEnd ? '0 : col + COL_W'(1);
        if (atRowEnd) begin
          rowReg <= atFrameEnd ? '0 : curRow + ROW_W'(1);
        end else begin
          rowReg <= curRow;
        end
      end
      if (adv) begin
        validPipe <= {validPipe[PIPE_STAGES-2:0], accept};
        lastPipe  <= {lastPipe[PIPE_STAGES-2:0], accept && atFrameEnd};
      end
    end
  end

endmodule

// File: rtl/conv3x3_datapath.sv
module conv3x3_datapath
  import conv3x3_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int CIN   = 16,
  parameter int COUT  = 16,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int CI_W   = (CIN > 1) ? $clog2(CIN) : 1,
  localparam int CO_W   = (COUT > 1) ? $clog2(COUT) : 1,
  localparam int ADDR_W = CO_W + CI_W + TAP_CODE_W,
  localparam int PS_W   = PROD_W + 4   // room for nine products
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pipe_ctrl_t            ctrl,
  input  logic [COL_W-1:0]      col,
  input  logic [CIN*PIX_W-1:0]  inData,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [PIX_W-1:0]      wrData,
  output logic [COUT*PIX_W-1:0] outData
);

  logic signed [PIX_W-1:0] lineA  [CIN][IMG_W];   // row two above
  logic signed [PIX_W-1:0] lineB  [CIN][IMG_W];   // row one above
  logic signed [PIX_W-1:0] win    [CIN][TAPS];
  logic signed [PIX_W-1:0] wgt    [COUT][CIN][TAPS];
  logic signed [PS_W-1:0]  tapSum [COUT][CIN];
  logic signed [PS_W-1:0]  tapSumNext [COUT][CIN];
  logic signed [ACC_W-1:0] chanSum [COUT];
  logic signed [ACC_W-1:0] chanSumNext [COUT];

  // ---------------- weight store ----------------
  logic [TAP_CODE_W-1:0] wrTap;
  logic [CI_W-1:0]       wrCi;
  logic [CO_W-1:0]       wrCo;
  logic                  wrHit;

  assign wrTap = wrAddr[TAP_CODE_W-1:0];
  assign wrCi  = wrAddr[TAP_CODE_W +: CI_W];
  assign wrCo  = wrAddr[TAP_CODE_W + CI_W +: CO_W];
  assign wrHit = wrEn
              && ({1'b0, wrTap} < (TAP_CODE_W + 1)'(TAPS))
              && ({1'b0, wrCi}  < (CI_W + 1)'(CIN))
              && ({1'b0, wrCo}  < (CO_W + 1)'(COUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int co = 0; co < COUT; co++)
        for (int ci = 0; ci < CIN; ci++)
          for (int t = 0; t < TAPS; t++)
            wgt[co][ci][t] <= '0;
    end else if (wrHit) begin
      wgt[wrCo][wrCi][wrTap] <= wrData;
    end
  end

  // ---------------- line buffers and window ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int ci = 0; ci < CIN; ci++) begin
        for (int x = 0; x < IMG_W; x++) begin
          lineA[ci][x] <= '0;
          lineB[ci][x] <= '0;
        end
        for (int t = 0; t < TAPS; t++) win[ci][t] <= '0;
      end
    end else if (ctrl.accept) begin
      for (int ci = 0; ci < CIN; ci++) begin
        if (ctrl.frameStart) begin
          for (int x = 0; x < IMG_W; x++) begin
            lineA[ci][x] <= '0;
            lineB[ci][x] <= '0;
          end
        end
        lineA[ci][col] <= ctrl.frameStart ? '0 : lineB[ci][col];
        lineB[ci][col] <= inData[ci*PIX_W +: PIX_W];
        for (int r = 0; r < 3; r++) begin
          win[ci][r*3]     <= ctrl.frameStart ? '0 : win[ci][r*3+1];
          win[ci][r*3 + 1] <= ctrl.frameStart ? '0 : win[ci][r*3+2];
        end
        win[ci][2] <= ctrl.frameStart ? '0 : lineA[ci][col];
        win[ci][5] <= ctrl.frameStart ? '0 : lineB[ci][col];
        win[ci][8] <= inData[ci*PIX_W +: PIX_W];
      end
    end
  end

  // ---------------- stage 1: nine-tap sum per (filter, channel) ----------------
  always_comb begin
    logic signed [PROD_W-1:0] opA;
    logic signed [PROD_W-1:0] opB;
    logic signed [PS_W-1:0]   run;
    for (int co = 0; co < COUT; co++) begin
      for (int ci = 0; ci < CIN; ci++) begin
        run = '0;
        for (int t = 0; t < TAPS; t++) begin
          opA = win[ci][t];
          opB = wgt[co][ci][t];
          run = run + PS_W'(opA * opB);
        end
        tapSumNext[co][ci] = run;
      end
    end
  end

  // ---------------- stage 2: sum over input channels ----------------
  always_comb begin
    logic signed [ACC_W-1:0] run;
    for (int co = 0; co < COUT; co++) begin
      run = '0;
      for (int ci = 0; ci < CIN; ci++) run = run + ACC_W'(tapSum[co][ci]);
      chanSumNext[co] = run;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int co = 0; co < COUT; co++) begin
        for (int ci = 0; ci < CIN; ci++) tapSum[co][ci] <= '0;
        chanSum[co] <= '0;
      end
      outData <= '0;
    end else if (ctrl.adv) begin
      for (int co = 0; co < COUT; co++) begin
        for (int ci = 0; ci < CIN; ci++) tapSum[co][ci] <= tapSumNext[co][ci];
        chanSum[co] <= chanSumNext[co];
        outData[co*PIX_W +: PIX_W] <= requantize(chanSum[co]);
      end
    end
  end

endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv3x3_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32,
  parameter int CIN   = 16,
  parameter int COUT  = 16,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int CI_W   = (CIN > 1) ? $clog2(CIN) : 1,
  localparam int CO_W   = (COUT > 1) ? $clog2(COUT) : 1,
  localparam int ADDR_W = CO_W + CI_W + TAP_CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  inSof,
  input  logic [CIN*PIX_W-1:0]  inData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [COUT*PIX_W-1:0] outData,
  output logic                  outLast,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [PIX_W-1:0]      wrData
);

  pipe_ctrl_t       ctrl;
  logic [COL_W-1:0] col;

  conv3x3_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrlI (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .outReady(outReady),
    .ctrl(ctrl), .col(col), .inReady(inReady), .outValid(outValid), .outLast(outLast)
  );

  conv3x3_datapath #(.IMG_W(IMG_W), .CIN(CIN), .COUT(COUT)) dpI (
    .clk(clk), .rst(rst), .ctrl(ctrl), .col(col), .inData(inData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outData(outData)
  );

endmodule

// File: rtl/conv3x3_stream_chk.sv
module conv3x3_stream_chk
  import conv3x3_pkg::*;
#(
  parameter int COUT = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inValid,
  input logic                  inReady,
  input logic                  outValid,
  input logic                  outReady,
  input logic [COUT*PIX_W-1:0] outData,
  input logic                  outLast
);

  logic [3:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else inFlight <= inFlight + 4'(inValid && inReady) - 4'(outValid && outReady);
  end

  // R1: reset leaves no output pending
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !outValid);

  // R9: a blocked output stops intake
  a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // R9: a blocked output word holds
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R10: the frame flag only marks a real output
  a_r10_last_qualified: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  // R8: every output has an accepted input behind it
  a_r8_output_has_source: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != 4'd0));

  // R8, R9: no more positions in flight than pipeline stages
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r8_inflight_bound: assert (inFlight <= 4'(PIPE_STAGES));
    end
  end

endmodule

bind conv3x3_stream conv3x3_stream_chk #(.COUT(COUT)) chkI (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
);

// File: tb/conv3x3_stream_tb_top.sv
module conv3x3_stream_tb_top;

  localparam int W = 5, H = 4, CIN = 3, COUT = 4;
  localparam int CI_W = 2, CO_W = 2, ADDR_W = CO_W + CI_W + 4;
  localparam int HIST = 4096;

  logic clk = 1'b0;
  logic rst;
  logic inValid, inReady, inSof, outValid, outReady, outLast, wrEn;
  logic [CIN*8-1:0]  inData;
  logic [COUT*8-1:0] outData;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0]        wrData;

  conv3x3_stream #(.IMG_W(W), .IMG_H(H), .CIN(CIN), .COUT(COUT)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inSof(inSof),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #4 clk = ~clk;   // 125 MHz

  int nChecks = 0;
  int nFails  = 0;
  byte signed wModel [COUT][CIN][9];
  logic [CIN*8-1:0]  hist [HIST];
  int histN = 0;
  int frameBase = 0;
  logic [COUT*8-1:0] expData [$];
  logic              expLast [$];
  logic [CIN*8-1:0]  stimPix [$];
  bit                stimSof [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected output for the position being accepted (R2, R3, R4, R5, R6, R10, R11).
  function automatic void pushExpected(input logic [CIN*8-1:0] pix, input bit sof);
    logic [COUT*8-1:0] word;
    int acc, m, posInFrame;
    byte signed v;
    if (sof) frameBase = histN;
    hist[histN] = pix;
    for (int co = 0; co < COUT; co++) begin
      acc = 0;
      for (int ci = 0; ci < CIN; ci++)
        for (int ky = 0; ky < 3; ky++)
          for (int kx = 0; kx < 3; kx++) begin
            m = histN - (2 - ky) * W - (2 - kx);
            v = (m >= frameBase) ? byte'(hist[m][ci*8 +: 8]) : 8'sd0;
            acc += int'(v) * int'(wModel[co][ci][ky*3 + kx]);
          end
      word[co*8 +: 8] = (acc < 0) ? 8'd0 : acc[15:8];
    end
    posInFrame = histN - frameBase;
    expData.push_back(word);
    expLast.push_back((posInFrame % (W * H)) == (W * H - 1));
    histN++;
  endfunction

  // mode 0: random weights, 1: all +127, 2: all -128 (R7)
  task automatic loadWeights(input int mode);
    for (int co = 0; co < COUT; co++)
      for (int ci = 0; ci < CIN; ci++)
        for (int t = 0; t < 9; t++) begin
          @(negedge clk);
          wModel[co][ci][t] = (mode == 0) ? byte'($urandom) : (mode == 1) ? 8'sd127 : -8'sd128;
          wrEn   = 1'b1;
          wrAddr = {2'(co), 2'(ci), 4'(t)};
          wrData = wModel[co][ci][t];
        end
    // R7: writes that must change nothing (tap codes 9..15, channel code 3 of 3)
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wrEn   = 1'b1;
      wrAddr = (k < 7) ? {2'($urandom_range(3)), 2'($urandom_range(2)), 4'(9 + k)}
                       : {2'd1, 2'd3, 4'd4};
      wrData = 8'($urandom);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // mode 0: random pixels, otherwise every sample equals value
  task automatic addStim(input int n, input bit sofFirst, input int mode, input byte value);
    for (int i = 0; i < n; i++) begin
      logic [CIN*8-1:0] p;
      for (int ci = 0; ci < CIN; ci++) p[ci*8 +: 8] = (mode == 0) ? 8'($urandom) : value;
      stimPix.push_back(p);
      stimSof.push_back(sofFirst && (i == 0));
    end
  endtask

  task automatic runStream(input int gapPct, input int stallPct, input string tag);
    bit held = 1'b0;
    logic [COUT*8-1:0] heldData = '0;
    bit heldLast = 1'b0;
    int guard = 0;
    while ((stimPix.size() != 0 || expData.size() != 0) && guard < 20000) begin
      bit inAcc, outAcc;
      guard++;
      @(negedge clk);
      outReady = ($urandom_range(99) >= stallPct);
      if (stimPix.size() != 0 && $urandom_range(99) >= gapPct) begin
        inValid = 1'b1;
        inData  = stimPix[0];
        inSof   = stimSof[0];
      end else begin
        inValid = 1'b0;
        inSof   = 1'b0;
        inData  = 8'($urandom);
      end
      #1;
      if (held) begin
        check(outValid && outData == heldData && outLast == heldLast, "R9 hold",
              {31'd0, outValid, outData}, {31'd1, heldData});
      end
      if (outValid && !outReady) check(!inReady, "R9 ready", inReady, 0);
      if (stallPct == 0 && stimPix.size() != 0) check(inReady, "R8 rate", inReady, 1);
      inAcc  = inValid && inReady;
      outAcc = outValid && outReady;
      if (outAcc) begin
        if (expData.size() == 0) begin
          check(1'b0, "R9 extra output", outData, 0);
        end else begin
          check(outData == expData[0], tag, outData, expData[0]);
          check(outLast == expLast[0], "R10 R11 last", outLast, expLast[0]);
          void'(expData.pop_front());
          void'(expLast.pop_front());
        end
      end
      if (inAcc) begin
        pushExpected(stimPix[0], stimSof[0]);
        void'(stimPix.pop_front());
        void'(stimSof.pop_front());
      end
      held     = outValid && !outReady;
      heldData = outData;
      heldLast = outLast;
    end
    @(negedge clk);
    inValid = 1'b0;
    inSof   = 1'b0;
    check(guard < 20000 && expData.size() == 0, "R9 drain", expData.size(), 0);
  endtask

  // R8: one position into an empty pipe, count negedges until outValid
  task automatic latencyProbe();
    int c = 0;
    logic [CIN*8-1:0] p;
    @(negedge clk);
    for (int ci = 0; ci < CIN; ci++) p[ci*8 +: 8] = 8'($urandom);
    outReady = 1'b1;
    inValid  = 1'b1;
    inSof    = 1'b1;
    inData   = p;
    #1;
    check(inReady, "R8 idle ready", inReady, 1);
    pushExpected(p, 1'b1);
    do begin
      @(negedge clk);
      inValid = 1'b0;
      inSof   = 1'b0;
      c++;
    end while (!outValid && c < 10);
    check(c == 4, "R8 latency", c, 4);
    check(outData == expData[0], "R3 R4 first position", outData, expData[0]);
    void'(expData.pop_front());
    void'(expLast.pop_front());
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst = 1'b1; inValid = 1'b0; inSof = 1'b0; inData = '0;
    outReady = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid && !outLast, "R1 outputs", {outValid, outLast}, 0);
    check(inReady, "R1 ready", inReady, 1);

    // Random weights, full-rate frames
    loadWeights(0);
    latencyProbe();
    addStim(W * H, 1, 0, 0);
    addStim(W * H, 1, 0, 0);
    runStream(0, 0, "R2 R4 R5 R6 R7");

    // Gaps and stalls; a restarted partial frame
    addStim(W * H, 1, 0, 0);
    addStim(7, 1, 0, 0);
    addStim(W * H, 1, 0, 0);
    runStream(30, 40, "R2 R3 R9");

    // No start of frame on the second frame: count wraps, history kept
    addStim(2 * W * H + 3, 1, 0, 0);
    runStream(10, 20, "R11 R2");

    // Saturating positive sum, byte truncation
    loadWeights(1);
    addStim(W * H, 1, 1, 8'sd127);
    runStream(0, 25, "R5 truncate");

    // Negative sums clamp to zero
    addStim(W * H, 1, 1, -8'sd128);
    runStream(20, 0, "R5 clamp");

    // Negative times negative
    loadWeights(2);
    addStim(W * H, 1, 1, -8'sd128);
    runStream(0, 0, "R4 R5 signed");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule